// File: doc/BRIEF.md
# Instruction Fetch Pointer with Segment Limit Stop

This block keeps the byte address of the next 32-bit instruction word that the prefetcher will request. Because every fetch moves a whole word, only the word-address bits are held in a register. An accepted fetch advances that register by one, which is the same as adding 4 to the byte address. A jump loads a new pointer, and a jump has priority over an advance in the same cycle.

A code-limit register sits next to the pointer. Each cycle a wide equality compare checks the pointer's word bits against it. While the two are equal, the block raises a stop flag and ignores accepted-fetch strobes. The stop lasts until a jump or a new limit breaks the equality.

The architectural instruction pointer is never stored. It is formed on demand by subtracting the prefetch queue's current byte count from the fetch address. The incrementer builds its carries from a per-bit ripple chain and a skip path that jumps over groups of bits. A parameter can select a plain ripple variant instead.

Top module: `fetch_ptr_ctl`

## Requirements
- R1: After reset, fetch_addr is 0, the limit register holds all ones in bits 31:2, and limit_hit is 0.
- R2: A cycle with fetch_ack high, jmp_load low and limit_hit low makes fetch_addr one word (4 bytes) larger on the next cycle.
- R3: When jmp_load is high, fetch_addr takes jmp_addr with bits 1:0 cleared on the next cycle, even if fetch_ack is high in the same cycle.
- R4: Bits 1:0 of fetch_addr are always 0, whatever value was loaded.
- R5: limit_hit is 1 exactly when bits 31:2 of fetch_addr equal bits 31:2 of the limit register; a mismatch in any single bit clears it.
- R6: While limit_hit is 1 and no jump is loaded, fetch_ack has no effect on fetch_addr.
- R7: A stop caused by limit_hit ends when a new limit or a new pointer is loaded that makes the two unequal; advancing then resumes.
- R8: When lim_load is high, the limit register takes lim_value bits 31:2 on the next cycle; lim_value bits 1:0 are ignored.
- R9: instr_ptr equals fetch_addr minus q_bytes, modulo 2^32, combinationally.
- R10: Advancing from byte address 0xFFFFFFFC wraps fetch_addr to 0.
- R11: The grouped carry incrementer gives the same result as a plain +1 for every word value, including runs of trailing ones that end inside a group, on a group boundary, or span several groups.

Grouped carry incrementer: the carry into each bit is computed first, and each result bit is then its input bit XORed with that carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| jmp_load | input | 1 | Load a new fetch pointer (jump) |
| jmp_addr | input | 32 | New pointer byte address; bits 1:0 are dropped |
| fetch_ack | input | 1 | Current word fetch was accepted |
| lim_load | input | 1 | Load a new code limit |
| lim_value | input | 32 | New limit byte address; bits 1:0 are ignored |
| q_bytes | input | 5 | Valid bytes currently held in the prefetch queue (0..16) |
| fetch_addr | output | 32 | Byte address of the next word to fetch |
| limit_hit | output | 1 | Pointer equals limit; fetching is stopped |
| instr_ptr | output | 32 | Derived architectural instruction pointer |

## Verification
Assertions check these rules on every cycle:
- the one-word advance after an accepted fetch;
- jump priority and low-bit clearing;
- the frozen pointer while the stop flag is high;
- agreement of the grouped incrementer with a reference +1 on whatever value the pointer holds.

Other behaviour can only be shown by the bench's directed scenarios:
- the exact reset values;
- limit loading with its low bits ignored;
- the stop being released by a limit or a pointer load;
- wrap-around at the top of the address space;
- the instruction-pointer subtraction, including a borrow below zero.

The bench also drives the pointer to chosen trailing-ones patterns at every bit position. That puts the carry into and across each group boundary, which random values seldom reach.

// File: rtl/fetch_ptr_pkg.sv
package fetch_ptr_pkg;

   // Incrementer carry structure variants.
   typedef enum logic {
      INC_RIPPLE = 1'b0,
      INC_SKIP   = 1'b1
   } inc_style_e;

   // Number of skip groups needed to cover w bits with groups of g bits.
   function automatic int grp_count(input int w, input int g);
      return (w + g - 1) / g;
   endfunction

endpackage

// File: rtl/fp_incr.sv
module fp_incr
   import fetch_ptr_pkg::*;
#(
   parameter int         W     = 30,
   parameter int         GRP   = 5,
   parameter inc_style_e STYLE = INC_SKIP
) (
   input  logic [W-1:0] a,
   output logic [W-1:0] y
);

   localparam int NGRP = grp_count(W, GRP);

   // Carry into each bit position.
   logic [W-1:0] cin;

   generate
      if (W < 2) begin : g_bad_w
         $error("fp_incr: W must be at least 2");
      end

      if (STYLE == INC_RIPPLE) begin : g_ripple
         assign cin[0] = 1'b1;
         for (genvar i = 1; i < W; i++) begin : g_bit
            assign cin[i] = cin[i-1] & a[i-1];
         end
      end else begin : g_skip
         if (GRP < 3 || GRP > 6) begin : g_bad_grp
            $error("fp_incr: GRP must lie between 3 and 6");
         end

         // Express carry entering each group.
         logic [NGRP:0] skip;
         assign skip[0] = 1'b1;

         for (genvar g = 0; g < NGRP; g++) begin : g_grp
            localparam int LO = g * GRP;
            localparam int HI = ((LO + GRP) < W) ? (LO + GRP - 1) : (W - 1);

            // Group passes the skip carry only when all its bits are ones.
            logic all_ones;
            assign all_ones    = &a[HI:LO];
            assign skip[g + 1] = skip[g] & all_ones;

            // Local chain inside the group, seeded by the skip carry.
            for (genvar i = LO; i <= HI; i++) begin : g_bit
               if (i == LO) begin : g_head
                  assign cin[i] = skip[g];
               end else begin : g_body
                  assign cin[i] = cin[i-1] & a[i-1];
               end
            end
         end

         logic unused_skip_out;
         assign unused_skip_out = skip[NGRP];
      end
   endgenerate

   // Toggle every bit that receives a carry.
   assign y = a ^ cin;

endmodule

// File: rtl/fp_limit_cmp.sv
module fp_limit_cmp #(
   parameter int W = 30
) (
   input  logic [W-1:0] ptr,
   input  logic [W-1:0] lim,
   output logic         match
);

   // One mismatch term per bit; the match line starts true and any term pulls it false.
   logic [W-1:0] miss;

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign miss[i] = ptr[i] ^ lim[i];
      end
   endgenerate

   assign match = ~(|miss);

endmodule

// File: rtl/fp_ip_recon.sv
module fp_ip_recon #(
   parameter int AW = 32,
   parameter int QW = 5
) (
   input  logic [AW-1:0] fetch_addr,
   input  logic [QW-1:0] q_bytes,
   output logic [AW-1:0] instr_ptr
);

   generate
      if (QW >= AW) begin : g_bad_qw
         $error("fp_ip_recon: queue count wider than address");
      end
   endgenerate

   logic [AW-1:0] q_ext;
   assign q_ext     = {{(AW-QW){1'b0}}, q_bytes};
   assign instr_ptr = fetch_addr - q_ext;

endmodule

// File: rtl/fetch_ptr_ctl.sv
module fetch_ptr_ctl
   import fetch_ptr_pkg::*;
#(
   parameter int         ADDR_W      = 32,
   parameter int         WORD_BYTES  = 4,
   parameter int         QUEUE_BYTES = 16,
   parameter int         SKIP_GRP    = 5,
   parameter inc_style_e INC_STYLE   = INC_SKIP,
   localparam int        LSB_W       = $clog2(WORD_BYTES),
   localparam int        WPTR_W      = ADDR_W - LSB_W,
   localparam int        QCNT_W      = $clog2(QUEUE_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              jmp_load,
   input  logic [ADDR_W-1:0] jmp_addr,
   input  logic              fetch_ack,
   input  logic              lim_load,
   input  logic [ADDR_W-1:0] lim_value,
   input  logic [QCNT_W-1:0] q_bytes,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic              limit_hit,
   output logic [ADDR_W-1:0] instr_ptr
);

   generate
      if (WORD_BYTES < 2 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
         $error("fetch_ptr_ctl: WORD_BYTES must be a power of two >= 2");
      end
      if (WPTR_W < 4) begin : g_bad_addr
         $error("fetch_ptr_ctl: ADDR_W too small for word size");
      end
      if (QCNT_W >= ADDR_W) begin : g_bad_queue
         $error("fetch_ptr_ctl: queue depth too large for address width");
      end
   endgenerate

   // Word-address state.
   logic [WPTR_W-1:0] ptr_q, ptr_d;
   logic [WPTR_W-1:0] lim_q, lim_d;
   logic [WPTR_W-1:0] ptr_inc;
   logic              adv;

   // Low address bits are dropped on purpose.
   logic unused_low_bits;
   assign unused_low_bits = ^{jmp_addr[LSB_W-1:0], lim_value[LSB_W-1:0]};

   fp_incr #(
      .W     (WPTR_W),
      .GRP   (SKIP_GRP),
      .STYLE (INC_STYLE)
   ) u_incr (
      .a (ptr_q),
      .y (ptr_inc)
   );

   fp_limit_cmp #(
      .W (WPTR_W)
   ) u_cmp (
      .ptr   (ptr_q),
      .lim   (lim_q),
      .match (limit_hit)
   );

   // Accepted fetches advance only while the stop flag is low.
   assign adv = fetch_ack & ~limit_hit;

   always_comb begin
      if (jmp_load) begin
         ptr_d = jmp_addr[ADDR_W-1:LSB_W];
      end else if (adv) begin
         ptr_d = ptr_inc;
      end else begin
         ptr_d = ptr_q;
      end
   end

   assign lim_d = lim_load ? lim_value[ADDR_W-1:LSB_W] : lim_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
         lim_q <= '1;
      end else begin
         ptr_q <= ptr_d;
         lim_q <= lim_d;
      end
   end

   assign fetch_addr = {ptr_q, {LSB_W{1'b0}}};

   fp_ip_recon #(
      .AW (ADDR_W),
      .QW (QCNT_W)
   ) u_ip (
      .fetch_addr (fetch_addr),
      .q_bytes    (q_bytes),
      .instr_ptr  (instr_ptr)
   );

   // R2: accepted fetch moves the address one word forward.
   a_r2_advance_one_word: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_ack && !jmp_load && !limit_hit) |=>
         (fetch_addr == $past(fetch_addr) + ADDR_W'(WORD_BYTES)));

   // R3: jump wins over advance and clears the low bits.
   a_r3_jump_priority: assert property (@(posedge clk) disable iff (!rst_n)
      jmp_load |=>
         (fetch_addr == {$past(jmp_addr[ADDR_W-1:LSB_W]), {LSB_W{1'b0}}}));

   // R6: with the stop flag high, strobes leave the address alone.
   a_r6_hold_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (limit_hit && !jmp_load) |=> $stable(fetch_addr));

   // R11: grouped incrementer agrees with a plain +1.
   a_r11_incr_matches_plus1: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_inc == ptr_q + WPTR_W'(1));

endmodule

// File: tb/fetch_ptr_ctl_tb.sv
`timescale 1ns/1ps
module fetch_ptr_ctl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        jmp_load = 1'b0;
   logic [31:0] jmp_addr = '0;
   logic        fetch_ack = 1'b0;
   logic        lim_load = 1'b0;
   logic [31:0] lim_value = '0;
   logic [4:0]  q_bytes = '0;
   logic [31:0] fetch_addr;
   logic        limit_hit;
   logic [31:0] instr_ptr;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   fetch_ptr_ctl u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .jmp_load   (jmp_load),
      .jmp_addr   (jmp_addr),
      .fetch_ack  (fetch_ack),
      .lim_load   (lim_load),
      .lim_value  (lim_value),
      .q_bytes    (q_bytes),
      .fetch_addr (fetch_addr),
      .limit_hit  (limit_hit),
      .instr_ptr  (instr_ptr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive one cycle of stimulus from a negedge, return at the next negedge.
   task automatic cyc(input logic jl, input logic [31:0] ja, input logic fa,
                      input logic ll, input logic [31:0] lv);
      jmp_load  = jl;
      jmp_addr  = ja;
      fetch_ack = fa;
      lim_load  = ll;
      lim_value = lv;
      @(negedge clk);
      jmp_load  = 1'b0;
      fetch_ack = 1'b0;
      lim_load  = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 addr", fetch_addr, 32'h0);
      chk("R1 hit", {31'b0, limit_hit}, 32'h0);
      chk("R1 ip", instr_ptr, 32'h0);
      // Limit register all ones: jump to the top word must report the stop.
      cyc(1, 32'hFFFF_FFFC, 0, 0, 0);
      chk("R1 limit reset value", {31'b0, limit_hit}, 32'h1);
   endtask

   task automatic t_jump();
      cyc(1, 32'h1234_5677, 0, 0, 0);
      chk("R3 R4 jump low bits", fetch_addr, 32'h1234_5674);
      cyc(1, 32'h0000_0041, 1, 0, 0);
      chk("R3 jump beats ack", fetch_addr, 32'h0000_0040);
   endtask

   task automatic t_advance();
      for (int i = 1; i <= 3; i++) begin
         cyc(0, 0, 1, 0, 0);
         chk("R2 advance", fetch_addr, 32'h40 + 32'(4 * i));
      end
      cyc(0, 0, 0, 0, 0);
      chk("R2 idle hold", fetch_addr, 32'h4C);
   endtask

   task automatic t_incr_random();
      for (int i = 0; i < 24; i++) begin
         logic [31:0] r;
         r = $urandom() & 32'h7FFF_FFFF;
         cyc(1, r, 0, 0, 0);
         cyc(0, 0, 1, 0, 0);
         chk("R11 random +4", fetch_addr, (r & 32'hFFFF_FFFC) + 32'd4);
      end
   endtask

   task automatic t_trailing();
      for (int k = 0; k < 30; k++) begin
         logic [29:0] w;
         logic [29:0] e;
         w = (30'h2AAA_AAAA & (~30'd0 << (k + 1))) | ((30'd1 << k) - 30'd1);
         e = w + 30'd1;
         cyc(1, {w, 2'b11}, 0, 0, 0);
         cyc(0, 0, 1, 0, 0);
         chk("R11 trailing ones", fetch_addr, {e, 2'b00});
         chk("R4 low bits zero", {30'b0, fetch_addr[1:0]}, 32'h0);
      end
   endtask

   task automatic t_wrap();
      cyc(0, 0, 0, 1, 32'h0000_0100);
      cyc(1, 32'hFFFF_FFFC, 0, 0, 0);
      chk("R10 pre-wrap no hit", {31'b0, limit_hit}, 32'h0);
      cyc(0, 0, 1, 0, 0);
      chk("R10 wrap", fetch_addr, 32'h0);
   endtask

   task automatic t_limit();
      cyc(0, 0, 0, 1, 32'h0000_1013);
      cyc(1, 32'h0000_1008, 0, 0, 0);
      chk("R5 below limit", {31'b0, limit_hit}, 32'h0);
      cyc(0, 0, 1, 0, 0);
      chk("R2 step toward limit", fetch_addr, 32'h100C);
      cyc(0, 0, 1, 0, 0);
      chk("R8 limit low bits ignored", fetch_addr, 32'h1010);
      chk("R5 R8 hit", {31'b0, limit_hit}, 32'h1);
      cyc(0, 0, 1, 0, 0);
      cyc(0, 0, 1, 0, 0);
      chk("R6 frozen", fetch_addr, 32'h1010);
      // One-bit mismatch clears the flag.
      cyc(0, 0, 0, 1, 32'h8000_1010);
      chk("R5 top bit mismatch", {31'b0, limit_hit}, 32'h0);
      cyc(0, 0, 0, 1, 32'h0000_1010);
      chk("R5 rehit", {31'b0, limit_hit}, 32'h1);
      cyc(0, 0, 0, 1, 32'h0000_2000);
      chk("R7 release by limit", {31'b0, limit_hit}, 32'h0);
      cyc(0, 0, 1, 0, 0);
      chk("R7 advance resumes", fetch_addr, 32'h1014);
      cyc(1, 32'h0000_2000, 0, 0, 0);
      chk("R7 jump onto limit", {31'b0, limit_hit}, 32'h1);
      cyc(1, 32'h0000_1FF0, 1, 0, 0);
      chk("R7 release by jump", {31'b0, limit_hit}, 32'h0);
      chk("R7 jump addr", fetch_addr, 32'h1FF0);
   endtask

   task automatic t_ip();
      q_bytes = 5'd16;
      #1;
      chk("R9 full queue", instr_ptr, 32'h1FE0);
      q_bytes = 5'd5;
      #1;
      chk("R9 partial", instr_ptr, 32'h1FEB);
      @(negedge clk);
      cyc(1, 32'h0000_0000, 0, 0, 0);
      q_bytes = 5'd3;
      #1;
      chk("R9 borrow", instr_ptr, 32'hFFFF_FFFD);
      q_bytes = 5'd0;
      @(negedge clk);
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_jump();
      t_advance();
      t_incr_random();
      t_trailing();
      t_wrap();
      t_limit();
      t_ip();
      finish_up();
   end

   initial begin
      #200000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

endmodule